// File: doc/BRIEF.md
# Byte-Mapped Double-Width Arithmetic Unit

This unit adds a 16-bit arithmetic and logic stage to an 8-bit processor. The processor does not see it as a separate port. Two operands, called A and B, and one result, called S, each take two byte-wide slots in the processor's data space. Software fills the operand slots with ordinary byte stores. It then issues one extended instruction: a 15-bit instruction word whose most-significant bit is set. That instruction runs a whole 16-bit operation in one clock cycle. Software collects the two result bytes with ordinary byte loads.

The unit also keeps a small status register. It holds the carry produced by the last extended operation and a flag that shows whether that result was zero. The rest of the processor pipeline (fetch, decode of ordinary instructions, the processor's own byte ALU) is outside this unit.

Top module: `wide_alu_unit`

## Requirements
- R1: After reset, all six mapped byte slots read 0x00, and `carry_out` and `zero_out` are 0.
- R2: Byte stores to 0x0C/0x0D set the high/low byte of A, and stores to 0x0E/0x0F set the high/low byte of B. Loads from these four addresses return the stored bytes in the same cycle. Loads from 0x10/0x11 return the high/low byte of S.
- R3: Stores to 0x10 or 0x11 leave S unchanged. Stores to an address outside 0x0C–0x11 change no register, and loads from such an address return 0x00.
- R4: An operation runs only when `xop_valid` is 1 and bit 14 of `xop_word` is 1 at a rising clock edge. In all other cases S and both flags keep their values.
- R5: Code 0 (bits 3:0 of `xop_word`) gives S = A + B + carry_in, with the carry out of bit 15 going to the carry flag.
- R6: Code 1 gives S = A − B − (1 − carry_in). The carry flag is set to 1 when no borrow occurred and to 0 when a borrow occurred.
- R7: Code 2 gives S = A + 1, with carry set when A was 0xFFFF. Code 3 gives S = A − 1, with carry set when A was not 0x0000.
- R8: Code 4 rotates right through the carry: S = {carry_in, A[15:1]} and the carry flag becomes A[0]. Code 5 rotates left through the carry: S = {A[14:0], carry_in} and the carry flag becomes A[15].
- R9: The remaining codes all clear the carry flag: code 6 swaps the bytes of A, codes 7, 8 and 9 apply bitwise AND, OR and XOR to A and B, and code 10 gives S = ~A. Codes 2–6 and 10 use A alone, so the value of B does not change their result.
- R10: Every operation with a code from 0 to 10 sets `zero_out` to 1 exactly when its 16-bit result is 0x0000.
- R11: Codes 11–15 leave S, `carry_out` and `zero_out` unchanged.
- R12: If an operation and a byte store to an operand slot happen in the same cycle, the operation uses the operand values from before the store. The store still takes effect.
- R13: The result and flags of an operation can be read at the ports in the cycle right after the edge that ran it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Data-space byte address |
| bus_wdata | input | 8 | Byte to store |
| bus_we | input | 1 | Store strobe |
| bus_rdata | output | 8 | Byte loaded from the addressed slot; 0x00 outside the window |
| xop_valid | input | 1 | An instruction word is being issued this cycle |
| xop_word | input | 15 | Instruction word; bit 14 marks extended, bits 3:0 give the operation code |
| carry_in | input | 1 | Carry input for add, subtract and the rotates |
| carry_out | output | 1 | Carry flag left by the last executed operation |
| zero_out | output | 1 | Zero flag left by the last executed operation |

## Verification
The bench builds the unit with its default parameters: 8-bit bytes, a 16-bit word, the window starting at 0x0C, and a 15-bit instruction word. With these values the whole 4-bit code space can be swept, including the five undefined codes. The carry and borrow boundaries at 0xFFFF and 0x0000 can be hit with a few stores. The addresses just outside the window, 0x0B and 0x12, can be probed directly. A behavioural model in the bench predicts every load, flag and result on each clock. Hand-worked cases pin down the rotate, borrow, and same-cycle store-and-execute orderings.

// File: rtl/walu_pkg.sv
// Package: shared operation codes and flag type for the byte-mapped 16-bit unit.
// Assumes codes above OP_CMPL are undefined and treated as no-ops by the decoder.
package walu_pkg;

    localparam int OP_W  = 4;
    localparam int N_OPS = 11;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_ROR  = 4'd4,
        OP_ROL  = 4'd5,
        OP_SWAP = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_CMPL = 4'd10
    } walu_op_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } walu_flags_t;

endpackage

// File: rtl/walu_decode.sv
// Module: instruction-word decoder.
// Turns an issued instruction word into a single execute pulse and an operation code.
// Assumes the top bit of the word marks an extended instruction and the low OP_W bits hold the code.
module walu_decode
    import walu_pkg::*;
#(
    parameter int INSN_W = 15
) (
    input  logic              xop_valid,
    input  logic [INSN_W-1:0] xop_word,
    output walu_op_e          op,
    output logic              run
);

    localparam int EXT_BIT = INSN_W - 1;

    logic [OP_W-1:0] code;
    logic            ext;
    logic            known;
    logic            unused_mid;

    // Pull out the marker bit and the operation field.
    always_comb begin
        ext   = xop_word[EXT_BIT];
        code  = xop_word[OP_W-1:0];
        known = (code < OP_W'(N_OPS));
    end

    assign unused_mid = ^xop_word[EXT_BIT-1:OP_W];

    // Run only an issued, extended, defined operation.
    assign run = xop_valid & ext & known;
    assign op  = walu_op_e'(code);

endmodule

// File: rtl/walu_regfile.sv
// Module: byte-mapped operand and result registers.
// Holds A and B as four writable bytes and S as a 16-bit register that only the datapath loads.
// Assumes the six slots are contiguous from BASE_ADDR, in the order A hi, A lo, B hi, B lo, S hi, S lo.
module walu_regfile #(
    parameter int                BYTE_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  res_load,
    input  logic [2*BYTE_W-1:0]   res_d,
    output logic [2*BYTE_W-1:0]   opa,
    output logic [2*BYTE_W-1:0]   opb,
    output logic [2*BYTE_W-1:0]   res_q,
    output logic [BYTE_W-1:0]     bus_rdata
);

    localparam int WORD_W   = 2 * BYTE_W;
    localparam int N_OPND   = 4;
    localparam int N_SLOTS  = N_OPND + 2;
    localparam int SLOT_SHI = N_OPND;
    localparam int SLOT_SLO = N_OPND + 1;

    logic [ADDR_W-1:0] rel;
    logic              in_win;
    logic [BYTE_W-1:0] opnd_q [N_OPND];

    // Offset of the bus address inside the window.
    always_comb begin
        rel    = bus_addr - BASE_ADDR;
        in_win = (rel < ADDR_W'(N_SLOTS));
    end

    // One store-only byte register per operand slot.
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (!rst_n)
                opnd_q[g] <= '0;
            else if (bus_we && in_win && (rel == ADDR_W'(g)))
                opnd_q[g] <= bus_wdata;
        end
    end

    // Result register, loaded only by an executed operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (res_load)
            res_q <= res_d;
    end

    assign opa = {opnd_q[0], opnd_q[1]};
    assign opb = {opnd_q[2], opnd_q[3]};

    // Same-cycle byte load from the addressed slot.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_OPND; i++) begin
            if (in_win && (rel == ADDR_W'(i)))
                bus_rdata = opnd_q[i];
        end
        if (in_win && (rel == ADDR_W'(SLOT_SHI)))
            bus_rdata = res_q[WORD_W-1:BYTE_W];
        if (in_win && (rel == ADDR_W'(SLOT_SLO)))
            bus_rdata = res_q[BYTE_W-1:0];
    end

endmodule

// File: rtl/walu_datapath.sv
// Module: combinational 16-bit operation stage.
// One shared adder serves add, subtract, increment and decrement. Rotates, swap and the logic ops are wiring and gates.
// Assumes op is a defined code when the result is used; undefined codes yield zero, which is discarded.
module walu_datapath
    import walu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  walu_op_e          op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              cin,
    output logic [WORD_W-1:0] res,
    output logic              cout
);

    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] add_y;
    logic              add_ci;
    logic [WORD_W:0]   add_sum;

    // Choose the second adder input and carry for the arithmetic codes.
    always_comb begin
        add_y  = '0;
        add_ci = 1'b0;
        case (op)
            OP_ADD: begin add_y = b;  add_ci = cin;  end
            OP_SUB: begin add_y = ~b; add_ci = cin;  end
            OP_INC: begin add_y = '0; add_ci = 1'b1; end
            OP_DEC: begin add_y = '1; add_ci = 1'b0; end
            default: ;
        endcase
    end

    // The single shared adder.
    assign add_sum = {1'b0, a} + {1'b0, add_y} + {{WORD_W{1'b0}}, add_ci};

    // Select the result and carry for the current code.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: {cout, res} = add_sum;
            OP_ROR: begin
                res  = {cin, a[WORD_W-1:1]};
                cout = a[0];
            end
            OP_ROL: begin
                res  = {a[WORD_W-2:0], cin};
                cout = a[WORD_W-1];
            end
            OP_SWAP: res = {a[HALF-1:0], a[WORD_W-1:HALF]};
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CMPL: res = ~a;
            default: ;
        endcase
    end

endmodule

// File: rtl/walu_status.sv
// Module: carry and zero status register.
// Updates both flags together whenever an operation is executed and otherwise holds them.
// Assumes load is asserted only for defined operation codes.
module walu_status
    import walu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] res_d,
    input  logic              cout_d,
    output logic              carry_q,
    output logic              zero_q
);

    walu_flags_t flags_q;

    // Capture carry and zero-detect of the new result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (load)
            flags_q <= '{carry: cout_d, zero: (res_d == '0)};
    end

    assign carry_q = flags_q.carry;
    assign zero_q  = flags_q.zero;

endmodule

// File: rtl/wide_alu_unit.sv
// Module: top of the byte-mapped 16-bit arithmetic unit.
// Joins the decoder, the byte-mapped registers, the datapath and the flags register. An operation reads
// the registered operands and writes S and the flags at the same edge, so a same-cycle store is not seen.
// Assumes the host presents at most one store and one instruction word per cycle.
module wide_alu_unit #(
    parameter int                BYTE_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0C,
    parameter int                INSN_W    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              xop_valid,
    input  logic [INSN_W-1:0] xop_word,
    input  logic              carry_in,
    output logic              carry_out,
    output logic              zero_out
);

    localparam int WORD_W = 2 * BYTE_W;

    walu_pkg::walu_op_e op;
    logic               run;
    logic [WORD_W-1:0]  opa;
    logic [WORD_W-1:0]  opb;
    logic [WORD_W-1:0]  res_q;
    logic [WORD_W-1:0]  res_d;
    logic               cout_d;

    walu_decode #(.INSN_W(INSN_W)) u_decode (
        .xop_valid (xop_valid),
        .xop_word  (xop_word),
        .op        (op),
        .run       (run)
    );

    walu_regfile #(
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .res_load  (run),
        .res_d     (res_d),
        .opa       (opa),
        .opb       (opb),
        .res_q     (res_q),
        .bus_rdata (bus_rdata)
    );

    walu_datapath #(.WORD_W(WORD_W)) u_path (
        .op   (op),
        .a    (opa),
        .b    (opb),
        .cin  (carry_in),
        .res  (res_d),
        .cout (cout_d)
    );

    walu_status #(.WORD_W(WORD_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (run),
        .res_d   (res_d),
        .cout_d  (cout_d),
        .carry_q (carry_out),
        .zero_q  (zero_out)
    );

endmodule

// File: rtl/wide_alu_unit_check.sv
// Module: property checker for wide_alu_unit, attached by the bind below.
// Watches the ports together with the operand and result registers.
module wide_alu_unit_check #(
    parameter int                BYTE_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0C,
    parameter int                INSN_W    = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic                  xop_valid,
    input logic [INSN_W-1:0]     xop_word,
    input logic                  carry_in,
    input logic [2*BYTE_W-1:0]   opa,
    input logic [2*BYTE_W-1:0]   opb,
    input logic [2*BYTE_W-1:0]   res_q,
    input logic                  carry_out,
    input logic                  zero_out
);

    localparam int WORD_W = 2 * BYTE_W;

    logic       issued;
    logic [3:0] code;
    logic       s_store;
    logic       unused_word;

    // Shorthands for the properties below.
    assign issued      = xop_valid && xop_word[INSN_W-1];
    assign code        = xop_word[3:0];
    assign s_store     = bus_we && ((bus_addr == BASE_ADDR + ADDR_W'(4)) ||
                                    (bus_addr == BASE_ADDR + ADDR_W'(5)));
    assign unused_word = ^xop_word[INSN_W-2:4];

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0 && opa == '0 && opb == '0 && !carry_out && !zero_out));

    p_hold_no_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !issued |=> ($stable(res_q) && $stable(carry_out) && $stable(zero_out)));

    p_s_store_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_store && !issued) |=> $stable(res_q));

    p_add_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && code == 4'd0) |=>
        ({carry_out, res_q} == ({1'b0, $past(opa)} + {1'b0, $past(opb)} +
                                 {{WORD_W{1'b0}}, $past(carry_in)})));

    p_zero_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && code <= 4'd10) |=> (zero_out == (res_q == '0)));

    p_undefined_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && code > 4'd10) |=> ($stable(res_q) && $stable(carry_out) && $stable(zero_out)));

    p_logic_no_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && code >= 4'd6 && code <= 4'd10) |=> !carry_out);

    p_ror_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && code == 4'd4) |=> (carry_out == $past(opa[0])));

endmodule

bind wide_alu_unit wide_alu_unit_check #(
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .INSN_W    (INSN_W)
) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .xop_valid (xop_valid),
    .xop_word  (xop_word),
    .carry_in  (carry_in),
    .opa       (opa),
    .opb       (opb),
    .res_q     (res_q),
    .carry_out (carry_out),
    .zero_out  (zero_out)
);

// File: tb/wide_alu_unit_test.sv
// Bench: behavioural reference model compared with the unit on every clock, plus hand-worked cases.
module wide_alu_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        xop_valid = 1'b0;
    logic [14:0] xop_word = '0;
    logic        carry_in = 1'b0;
    logic        carry_out;
    logic        zero_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state: A, B, S and flags as plain integers.
    int ma = 0, mb = 0, ms = 0, mc = 0, mz = 0;
    int last_rd = 0, last_c = 0, last_z = 0;

    always #5 clk = ~clk;

    wide_alu_unit uut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_we (bus_we), .bus_rdata (bus_rdata), .xop_valid (xop_valid),
        .xop_word (xop_word), .carry_in (carry_in), .carry_out (carry_out),
        .zero_out (zero_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input int addr);
        case (addr)
            'h0C: return ma / 256;
            'h0D: return ma % 256;
            'h0E: return mb / 256;
            'h0F: return mb % 256;
            'h10: return ms / 256;
            'h11: return ms % 256;
            default: return 0;
        endcase
    endfunction

    // One clock: drive, compare before the edge, advance the model at the edge.
    task automatic step(input int addr, input int wd, input bit we, input bit xv,
                        input int word, input int cin, input string tag);
        int code, t, s, c;
        bit hit;
        @(negedge clk);
        bus_addr  = addr[7:0];
        bus_wdata = wd[7:0];
        bus_we    = we;
        xop_valid = xv;
        xop_word  = word[14:0];
        carry_in  = cin[0];
        #1;
        last_rd = int'(bus_rdata);
        last_c  = int'(carry_out);
        last_z  = int'(zero_out);
        check({tag, " load"},  last_rd, model_read(addr));
        check({tag, " carry"}, last_c, mc);
        check({tag, " zero"},  last_z, mz);
        @(posedge clk);
        code = word % 16;
        hit  = xv && ((word / 16384) % 2 == 1);
        s = 0; c = 0;
        case (code)
            0:  begin t = ma + mb + cin; s = t % 65536; c = int'(t >= 65536); end
            1:  begin t = ma - mb - (1 - cin); c = int'(t >= 0); s = (t + 131072) % 65536; end
            2:  begin t = ma + 1; s = t % 65536; c = int'(t == 65536); end
            3:  begin c = int'(ma != 0); s = (ma + 65535) % 65536; end
            4:  begin s = cin * 32768 + ma / 2; c = ma % 2; end
            5:  begin s = (ma * 2) % 65536 + cin; c = ma / 32768; end
            6:  s = (ma % 256) * 256 + ma / 256;
            7:  s = ma & mb;
            8:  s = ma | mb;
            9:  s = ma ^ mb;
            10: s = 65535 - ma;
            default: hit = 0;
        endcase
        if (hit) begin
            ms = s; mc = c; mz = int'(s == 0);
        end
        if (we) begin
            case (addr)
                'h0C: ma = (wd % 256) * 256 + ma % 256;
                'h0D: ma = (ma / 256) * 256 + wd % 256;
                'h0E: mb = (wd % 256) * 256 + mb % 256;
                'h0F: mb = (mb / 256) * 256 + wd % 256;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input int addr, input int data, input string tag);
        step(addr, data, 1'b1, 1'b0, 0, 0, tag);
    endtask

    task automatic run_op(input int code, input int cin, input string tag);
        step(0, 0, 1'b0, 1'b1, 16384 + code, cin, tag);
    endtask

    task automatic peek(input int addr, input int exp, input string tag);
        step(addr, 0, 1'b0, 1'b0, 0, 0, tag);
        check({tag, " fixed"}, last_rd, exp);
    endtask

    task automatic peek_s(input int exp_s, input int exp_c, input int exp_z, input string tag);
        peek('h10, exp_s / 256, tag);
        peek('h11, exp_s % 256, tag);
        check({tag, " carry fixed"}, last_c, exp_c);
        check({tag, " zero fixed"},  last_z, exp_z);
    endtask

    task automatic set_ab(input int a, input int b, input string tag);
        wr('h0C, a / 256, tag); wr('h0D, a % 256, tag);
        wr('h0E, b / 256, tag); wr('h0F, b % 256, tag);
    endtask

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every slot and both flags
        for (int k = 'h0C; k <= 'h11; k++) peek(k, 0, "R1 reset slot");
        check("R1 carry", last_c, 0);
        check("R1 zero", last_z, 0);

        // R2: store and load back the operand bytes
        set_ab('h1234, 'hA5C3, "R2 store");
        peek('h0C, 'h12, "R2 A hi"); peek('h0D, 'h34, "R2 A lo");
        peek('h0E, 'hA5, "R2 B hi"); peek('h0F, 'hC3, "R2 B lo");

        // R5, R10, R13: carry out of bit 15 with zero result, visible the next cycle
        set_ab('hFFFF, 'h0001, "R5 setup");
        run_op(0, 0, "R5 add");
        peek_s('h0000, 1, 1, "R5 R10 R13 add wrap");
        run_op(0, 1, "R5 add cin");
        peek_s('h0001, 1, 0, "R5 add with carry");

        // R6: borrow on subtract
        set_ab('h1234, 'h1235, "R6 setup");
        run_op(1, 1, "R6 sub");
        peek_s('hFFFF, 0, 0, "R6 borrow");
        run_op(1, 0, "R6 sub borrow in");
        peek_s('hFFFE, 0, 0, "R6 borrow in");

        // R7: increment and decrement edges
        set_ab('hFFFF, 'h0F0F, "R7 setup");
        run_op(2, 0, "R7 inc");
        peek_s('h0000, 1, 1, "R7 inc wrap");
        set_ab('h0000, 'h0F0F, "R7 setup dec");
        run_op(3, 0, "R7 dec");
        peek_s('hFFFF, 0, 0, "R7 dec wrap");

        // R8: rotates through carry
        set_ab('h8001, 'h0000, "R8 setup");
        run_op(4, 1, "R8 ror");
        peek_s('hC000, 1, 0, "R8 ror");
        run_op(5, 0, "R8 rol");
        peek_s('h0002, 1, 0, "R8 rol");

        // R9: swap and complement ignore B; logic ops clear carry
        set_ab('h1234, 'hFFFF, "R9 setup");
        run_op(6, 1, "R9 swap");
        peek_s('h3412, 0, 0, "R9 swap B ignored");
        wr('h0E, 'h00, "R9 change B");
        run_op(10, 1, "R9 cmpl");
        peek_s('hEDCB, 0, 0, "R9 complement");
        set_ab('hF0F0, 'h0FF0, "R9 logic setup");
        run_op(7, 1, "R9 and");
        peek_s('h00F0, 0, 0, "R9 and");
        run_op(8, 0, "R9 or");
        peek_s('hFFF0, 0, 0, "R9 or");
        run_op(9, 0, "R9 xor");
        peek_s('hFF00, 0, 0, "R9 xor");

        // R11: undefined codes leave S and flags
        for (int k = 11; k < 16; k++) run_op(k, 1, "R11 undefined code");
        peek_s('hFF00, 0, 0, "R11 held");

        // R4: unmarked word and missing strobe do not execute
        step(0, 0, 1'b0, 1'b1, 0, 1, "R4 marker clear");
        step(0, 0, 1'b0, 1'b0, 16384 + 10, 1, "R4 strobe low");
        peek_s('hFF00, 0, 0, "R4 held");

        // R3: result slots are not writable; outside addresses not decoded
        wr('h10, 'h55, "R3 store S hi");
        wr('h11, 'h66, "R3 store S lo");
        wr('h0B, 'h77, "R3 store below");
        wr('h12, 'h88, "R3 store above");
        peek_s('hFF00, 0, 0, "R3 S held");
        peek('h0B, 0, "R3 load below");
        peek('h12, 0, "R3 load above");
        peek('h0C, 'hF0, "R3 A hi intact");
        peek('h0F, 'hF0, "R3 B lo intact");

        // R12: store and operation in the same cycle
        set_ab('h0001, 'h0001, "R12 setup");
        step('h0D, 'h05, 1'b1, 1'b1, 16384 + 0, 0, "R12 store with add");
        peek_s('h0002, 0, 0, "R12 old operand used");
        peek('h0D, 'h05, "R12 store landed");

        // R5-R10 sweep: model comparison over mixed operands, codes and carries
        seed = 32'h1ACE;
        for (int i = 0; i < 96; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            if (i % 3 == 0) set_ab((seed / 7) % 65536, (seed / 131) % 65536, "R2 sweep store");
            run_op(i % 16, (i / 16) % 2, "R5 R6 R7 R8 R9 R10 sweep op");
            peek('h10, model_read('h10), "R13 sweep read");
        end
        step(0, 0, 1'b0, 1'b0, 0, 0, "final idle");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule